// File: doc/BRIEF.md
# Lockable Control Register File

This block is a small bank of 16-bit control registers on a plain synchronous read/write bus. Software uses it to hold configuration words for a downstream function. Software can prove that the bank works by writing complementary patterns, reading them back and comparing the results with known values. The bank also holds a lock register. Each lock bit can be set once, and a set bit write-protects one data register until the next power-on reset. A soft-reset pulse returns the data registers to their defaults. It leaves the lock state alone, so protection stays in force across a soft reset.

The bus never stalls. A write takes effect at the clock edge on which `wr_en` is sampled high. A read that is sampled on an edge presents its data, with `rd_valid` high, for the whole of the next cycle. A read and a write may share a cycle. In that case the read returns the contents that were present before the write. There is no back-pressure, because the bank accepts every access in the cycle it arrives.

Top module: `ctlreg_bank`

## Requirements
- R1: A write to data register i (address i, 0..7) stores all 16 bits, and patterns such as 0xA5A5, 0x5A5A, 0xFFFF and 0x0000 read back exactly as written. A read sampled on an edge gives its data on `rd_data`, with `rd_valid` high, during the following cycle.
- R2: After power-on reset (`rst_n` low), data register i holds (0x0C30 + i*0x1001) mod 2^16, and the lock register (address 8) reads 0.
- R3: A one-cycle `soft_rst` pulse returns every data register to the value given in R2, whatever was written before.
- R4: A write to the lock register ORs bits [7:0] of `wdata` into the lock bits. A lock bit that is set cannot be cleared by any write.
- R5: Only lock bits 1..7 exist. Lock bit 0 and bits 15:8 always read 0, so data register 0 stays writable at all times.
- R6: A write to data register i has no effect while lock bit i is set.
- R7: Soft reset does not change the lock register. Only power-on reset clears it.
- R8: Reads of addresses 9..15 return 0, and writes to those addresses change no register.
- R9: In a cycle where `soft_rst` is high, every write is dropped, including a write to the lock register, and the soft reset takes effect.
- R10: A read in the same cycle as a write to the same address returns the old value. In a cycle after no read was sampled, `rd_data` is 0 and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| soft_rst | input | 1 | Synchronous one-cycle soft reset for the data registers |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Register address: 0..7 data, 8 lock, 9..15 unmapped |
| wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data, registered |
| rd_valid | output | 1 | High in the cycle that follows a sampled read |

## Verification
Every internal fault shows up at the ports through a read. A wrong stored value, a lock bit that fell, or a missed soft reset appears in `rd_data` in the cycle after the next read of the affected address. The bench therefore reads back every address after each kind of stimulus: pattern writes, locked writes, unmapped writes, soft reset alone, and soft reset combined with a write. A reference model predicts every returned word, and each cycle is compared against it.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int unsigned DATA_W = 16;
  typedef logic [DATA_W-1:0] word_t;

  // Default value of data register idx: seed plus idx copies of 0x1001.
  function automatic word_t reset_value(input word_t seed, input int unsigned idx);
    word_t step;
    step = word_t'(idx) * word_t'(16'h1001);
    return word_t'(seed + step);
  endfunction
endpackage

// File: rtl/ctlreg_decode.sv
module ctlreg_decode #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic                soft_rst,
  output logic [NUM_REGS-1:0] reg_sel,
  output logic                lock_sel,
  output logic [NUM_REGS-1:0] reg_wr,
  output logic                lock_wr
);
  localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(NUM_REGS);

  logic wr_ok;
  assign wr_ok = wr_en && !soft_rst;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign reg_sel[i] = (addr == ADDR_W'(i));
    assign reg_wr[i]  = reg_sel[i] && wr_ok;
  end

  assign lock_sel = (addr == LOCK_ADDR);
  assign lock_wr  = lock_sel && wr_ok;
endmodule

// File: rtl/ctlreg_lock.sv
module ctlreg_lock #(
  parameter int unsigned          NUM_REGS = 8,
  parameter logic [NUM_REGS-1:0]  LOCKABLE = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [NUM_REGS-1:0] set_bits,
  output logic [NUM_REGS-1:0] lock_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  lock_q <= '0;
    else if (wr) lock_q <= lock_q | (set_bits & LOCKABLE);
  end

  // R4
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q & $past(lock_q)) == $past(lock_q));

  // R5
  lock_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q & ~LOCKABLE) == '0);
endmodule

// File: rtl/ctlreg_cell.sv
module ctlreg_cell #(
  parameter ctlreg_pkg::word_t RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr,
  input  logic              locked,
  input  ctlreg_pkg::word_t wdata,
  output ctlreg_pkg::word_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              q <= RST_VAL;
    else if (soft_rst)       q <= RST_VAL;
    else if (wr && !locked)  q <= wdata;
  end

  // R6
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && locked && !soft_rst) |=> $stable(q));

  // R3
  soft_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (q == RST_VAL));

  // R1
  write_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !locked && !soft_rst) |=> (q == $past(wdata)));
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank #(
  parameter int unsigned             NUM_REGS = 8,
  parameter int unsigned             ADDR_W   = 4,
  parameter logic [NUM_REGS-1:0]     LOCKABLE = 8'hFE,
  parameter ctlreg_pkg::word_t       RST_SEED = 16'h0C30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0] wdata,
  output logic [15:0] rd_data,
  output logic        rd_valid
);
  import ctlreg_pkg::*;

  logic [NUM_REGS-1:0] reg_sel;
  logic [NUM_REGS-1:0] reg_wr;
  logic                lock_sel;
  logic                lock_wr;
  logic [NUM_REGS-1:0] lock_q;
  word_t               q [NUM_REGS];
  word_t               rd_mux;

  ctlreg_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_decode (
    .addr     (addr),
    .wr_en    (wr_en),
    .soft_rst (soft_rst),
    .reg_sel  (reg_sel),
    .lock_sel (lock_sel),
    .reg_wr   (reg_wr),
    .lock_wr  (lock_wr)
  );

  ctlreg_lock #(.NUM_REGS(NUM_REGS), .LOCKABLE(LOCKABLE)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (lock_wr),
    .set_bits (wdata[NUM_REGS-1:0]),
    .lock_q   (lock_q)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_cell
    ctlreg_cell #(.RST_VAL(reset_value(RST_SEED, i))) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .wr       (reg_wr[i]),
      .locked   (lock_q[i]),
      .wdata    (wdata),
      .q        (q[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (reg_sel[i]) rd_mux = q[i];
    end
    if (lock_sel) rd_mux = DATA_W'(lock_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_data  <= rd_en ? rd_mux : '0;
      rd_valid <= rd_en;
    end
  end

  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !(|reg_sel) && !lock_sel) |=> (rd_data == '0));

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rd_data == '0 && !rd_valid));

  // R7
  lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> $stable(lock_q));
endmodule

// File: tb/ctlreg_bank_bench.sv
module ctlreg_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rd_data;
  logic        rd_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] m_reg [8];
  logic [7:0]  m_lock;

  always #5 clk = ~clk;

  ctlreg_bank u_ctlreg_bank (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [15:0] dflt(input int i);
    return 16'(32'h0C30 + i * 32'h1001);
  endfunction

  function automatic logic [15:0] model_read(input logic [3:0] a);
    if (a < 4'd8)       return m_reg[a[2:0]];
    else if (a == 4'd8) return {8'h00, m_lock};
    else                return 16'h0000;
  endfunction

  task automatic model_defaults();
    for (int i = 0; i < 8; i++) m_reg[i] = dflt(i);
  endtask

  task automatic check(input string tag, input logic [15:0] ed, input logic ev);
    checks++;
    if (rd_data !== ed || rd_valid !== ev) begin
      fails++;
      $display("FAIL %s: rd_data=%h rd_valid=%b expected %h/%b", tag, rd_data, rd_valid, ed, ev);
    end
  endtask

  // Called at a falling edge; drives one cycle and compares the result.
  task automatic step(input logic we, input logic re, input logic [3:0] a,
                      input logic [15:0] wd, input logic sr, input string tag);
    logic [15:0] ed;
    logic        ev;
    wr_en = we; rd_en = re; addr = a; wdata = wd; soft_rst = sr;
    @(posedge clk);
    ev = re;
    ed = re ? model_read(a) : 16'h0000;
    if (sr) model_defaults();
    else if (we) begin
      if (a < 4'd8) begin
        if (!m_lock[a[2:0]]) m_reg[a[2:0]] = wd;
      end else if (a == 4'd8) m_lock = m_lock | (wd[7:0] & 8'hFE);
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; soft_rst = 1'b0;
    check(tag, ed, ev);
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    step(1'b0, 1'b1, a, 16'h0, 1'b0, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input string tag);
    step(1'b1, 1'b0, a, d, 1'b0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model_defaults();
    m_lock = 8'h00;
    repeat (3) @(negedge clk);
    check("R2", 16'h0000, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: power-on defaults and cleared lock
    for (int i = 0; i <= 8; i++) rd(4'(i), "R2");

    // R1: complementary patterns
    for (int i = 0; i < 8; i++) begin wr(4'(i), 16'hA5A5, "R1"); rd(4'(i), "R1"); end
    for (int i = 0; i < 8; i++) begin wr(4'(i), 16'h5A5A, "R1"); rd(4'(i), "R1"); end
    wr(4'd5, 16'hFFFF, "R1"); rd(4'd5, "R1");
    wr(4'd6, 16'h0000, "R1"); rd(4'd6, "R1");

    // R10: same-cycle read and write return old data; idle gives zero
    step(1'b1, 1'b1, 4'd3, 16'h1234, 1'b0, "R10");
    rd(4'd3, "R10");
    step(1'b0, 1'b0, 4'd3, 16'h0, 1'b0, "R10");

    // R8: unmapped addresses
    for (int a = 9; a < 16; a++) wr(4'(a), 16'hBEEF, "R8");
    for (int a = 9; a < 16; a++) rd(4'(a), "R8");
    for (int i = 0; i <= 8; i++) rd(4'(i), "R8");

    // R3: soft reset restores defaults
    step(1'b0, 1'b0, 4'd0, 16'h0, 1'b1, "R3");
    for (int i = 0; i < 8; i++) rd(4'(i), "R3");

    // R9: soft reset beats a write in the same cycle
    step(1'b1, 1'b0, 4'd2, 16'hDEAD, 1'b1, "R9");
    rd(4'd2, "R9");
    step(1'b1, 1'b0, 4'd8, 16'h00FF, 1'b1, "R9");
    rd(4'd8, "R9");

    // R4: lock bits set and stay set
    wr(4'd8, 16'h0006, "R4"); rd(4'd8, "R4");
    wr(4'd8, 16'h0000, "R4"); rd(4'd8, "R4");
    wr(4'd8, 16'h0010, "R4"); rd(4'd8, "R4");

    // R6: locked registers ignore writes, unlocked still accept
    wr(4'd1, 16'h1111, "R6"); rd(4'd1, "R6");
    wr(4'd2, 16'h2222, "R6"); rd(4'd2, "R6");
    wr(4'd4, 16'h4444, "R6"); rd(4'd4, "R6");
    wr(4'd3, 16'h3333, "R6"); rd(4'd3, "R6");

    // R7: soft reset leaves the lock in force
    step(1'b0, 1'b0, 4'd0, 16'h0, 1'b1, "R7");
    rd(4'd8, "R7");
    wr(4'd1, 16'h7777, "R7"); rd(4'd1, "R7");

    // R5: lock bit 0 and upper bits do not exist
    wr(4'd8, 16'hFFFF, "R5"); rd(4'd8, "R5");
    wr(4'd0, 16'hC0DE, "R5"); rd(4'd0, "R5");
    wr(4'd7, 16'h0707, "R5"); rd(4'd7, "R5");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule